// File: doc/BRIEF.md
# Peripheral Clock Gating Controller

This block decides, for each of 160 peripherals, whether that peripheral's clock keeps running. Software owns five 32-bit sleep-enable words. Each peripheral drives a clock-request line that says it still needs its clock. A peripheral's clock is removed only when two things are true at once: software has set its sleep-enable bit, and the peripheral has dropped its request. Three peripherals have no internal gating of their own (bits 26, 27 and 28 of word 3). For them the request line is ignored and the sleep-enable bit alone decides. The per-peripheral enables are registered, which stands in for glitch-free gate cells.

The block also holds a slow-clock divider that works from the bus clock. A value N emits a one-cycle enable tick every N bus cycles, and a value of zero stops the slow clock. Software reaches everything through a simple register port. A write takes one cycle. A read returns its data one cycle after the address is presented. Request status can be read back through five read-only words. The port is plain control, with no valid/ready handshake: every write is accepted in its cycle and every read completes in fixed time.

Top module: `periph_clk_gate_ctrl`

## Requirements
- R1: Addresses 0 to 4 hold the sleep-enable words. They can be written and read back. Bit i of word k controls peripheral 32*k+i.
- R2: Addresses 5 to 9 read the clk_req inputs. Peripheral 32*k+i appears at bit i of address 5+k. Writes to these addresses change no state.
- R3: For a peripheral that does gate internally, clk_en is low only when its sleep bit is set and its clk_req is low. clk_en changes on the first clock edge after the sleep bit or the request changes, and never within the same cycle.
- R4: When a peripheral's sleep bit is clear, its clk_en is high whatever its request.
- R5: For peripherals 122, 123 and 124 (word 3, bits 26 to 28), clk_req is ignored. clk_en is the inverse of the sleep bit.
- R6: After reset, words 0, 1, 2 and 4 read 0 and word 3 reads 0x1C000000. clk_en is high for every peripheral except 122 to 124. The divider reads 0.
- R7: Address 10 holds the divider in its low 8 bits. While it is zero, slow_tick stays low.
- R8: With a divider N greater than zero, slow_tick is high for one cycle every N cycles. The first tick comes N edges after the write edge. Each write restarts the count, so no tick arrives early.
- R9: rd_data shows the register selected by rd_addr one clock edge later. Addresses above 10 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 32 | Registered read data |
| clk_req | input | 160 | Per-peripheral clock request |
| clk_en | output | 160 | Per-peripheral registered clock enable |
| slow_tick | output | 1 | Slow-clock enable pulse |

## Verification
The hardest case to reach is a divider rewrite that lands on the very edge where the old count would have produced a tick. The stimulus writes a divider of 4, lets three cycles pass, and writes 4 again so that the second write edge lines up with the due tick. It then expects a clean four-cycle wait before the first tick. Request lines are also changed while the sleep bits are set, and clk_en is sampled both just after the change and after the next edge. This shows the enable is registered and not combinational.

// File: rtl/pcg_pkg.sv
package pcg_pkg;
  function automatic int unsigned status_base(int unsigned nregs);
    return nregs;
  endfunction

  function automatic int unsigned div_addr(int unsigned nregs);
    return 2 * nregs;
  endfunction
endpackage

// File: rtl/pcg_sleep_regs.sv
module pcg_sleep_regs #(
  parameter int NUM_REGS = 5,
  parameter int REG_W    = 32,
  parameter int ADDR_W   = 4,
  parameter logic [NUM_REGS*REG_W-1:0] RST_VAL = '0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [REG_W-1:0]          wr_data,
  output logic [NUM_REGS*REG_W-1:0] sleep_vec
);
  for (genvar k = 0; k < NUM_REGS; k++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        sleep_vec[k*REG_W +: REG_W] <= RST_VAL[k*REG_W +: REG_W];
      else if (wr_en && (wr_addr == ADDR_W'(k)))
        sleep_vec[k*REG_W +: REG_W] <= wr_data;
    end
  end
endmodule

// File: rtl/pcg_gate_bank.sv
module pcg_gate_bank #(
  parameter int NPER = 160,
  parameter logic [NPER-1:0] NOGATE_MASK = '0,
  parameter logic [NPER-1:0] SLEEP_RST   = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPER-1:0] sleep_vec,
  input  logic [NPER-1:0] clk_req,
  output logic [NPER-1:0] clk_en
);
  for (genvar g = 0; g < NPER; g++) begin : g_bit
    logic en_d;
    if (NOGATE_MASK[g]) begin : g_plain
      assign en_d = ~sleep_vec[g];
    end else begin : g_gated
      assign en_d = ~sleep_vec[g] | clk_req[g];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) clk_en[g] <= ~SLEEP_RST[g];
      else        clk_en[g] <= en_d;
    end
  end
endmodule

// File: rtl/pcg_slow_div.sv
module pcg_slow_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIV_W-1:0] load_val,
  output logic [DIV_W-1:0] div_q,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic             at_end;

  assign at_end = (div_q != '0) && (cnt == div_q - DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt   <= '0;
      tick  <= 1'b0;
    end else if (load) begin
      div_q <= load_val;
      cnt   <= '0;
      tick  <= 1'b0;
    end else begin
      tick <= at_end;
      if (at_end || div_q == '0) cnt <= '0;
      else                       cnt <= cnt + DIV_W'(1);
    end
  end
endmodule

// File: rtl/periph_clk_gate_ctrl.sv
module periph_clk_gate_ctrl #(
  parameter int NUM_REGS = 5,
  parameter int REG_W    = 32,
  parameter int ADDR_W   = 4,
  parameter int DIV_W    = 8,
  parameter int NG_REG   = 3,
  parameter int NG_LO    = 26,
  parameter int NG_HI    = 28
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [REG_W-1:0]          wr_data,
  input  logic [ADDR_W-1:0]         rd_addr,
  output logic [REG_W-1:0]          rd_data,
  input  logic [NUM_REGS*REG_W-1:0] clk_req,
  output logic [NUM_REGS*REG_W-1:0] clk_en,
  output logic                      slow_tick
);
  import pcg_pkg::*;

  localparam int NPER     = NUM_REGS * REG_W;
  localparam int STAT_A   = status_base(NUM_REGS);
  localparam int DIV_A    = div_addr(NUM_REGS);

  function automatic logic [NPER-1:0] mk_nogate();
    logic [NPER-1:0] m;
    for (int i = 0; i < NPER; i++)
      m[i] = (i >= NG_REG*REG_W + NG_LO) && (i <= NG_REG*REG_W + NG_HI);
    return m;
  endfunction

  localparam logic [NPER-1:0] NOGATE_MASK = mk_nogate();

  logic [NPER-1:0]  sleep_vec;
  logic [DIV_W-1:0] div_q;
  logic             div_wr;
  logic [REG_W-1:0] rd_next;

  assign div_wr = wr_en && (wr_addr == ADDR_W'(DIV_A));

  pcg_sleep_regs #(
    .NUM_REGS(NUM_REGS), .REG_W(REG_W), .ADDR_W(ADDR_W), .RST_VAL(NOGATE_MASK)
  ) u_sleep (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sleep_vec(sleep_vec)
  );

  pcg_gate_bank #(
    .NPER(NPER), .NOGATE_MASK(NOGATE_MASK), .SLEEP_RST(NOGATE_MASK)
  ) u_gate (
    .clk(clk), .rst_n(rst_n), .sleep_vec(sleep_vec),
    .clk_req(clk_req), .clk_en(clk_en)
  );

  pcg_slow_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .load(div_wr), .load_val(wr_data[DIV_W-1:0]),
    .div_q(div_q), .tick(slow_tick)
  );

  always_comb begin
    rd_next = '0;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (rd_addr == ADDR_W'(k))          rd_next = sleep_vec[k*REG_W +: REG_W];
      if (rd_addr == ADDR_W'(STAT_A + k)) rd_next = clk_req[k*REG_W +: REG_W];
    end
    if (rd_addr == ADDR_W'(DIV_A)) rd_next = REG_W'(div_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= rd_next;
  end
endmodule

// File: rtl/pcg_checker.sv
module pcg_checker #(
  parameter int NPER  = 160,
  parameter int DIV_W = 8,
  parameter logic [NPER-1:0] NOGATE_MASK = '0
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPER-1:0]  sleep_vec,
  input logic [NPER-1:0]  clk_req,
  input logic [NPER-1:0]  clk_en,
  input logic [DIV_W-1:0] div_q,
  input logic             slow_tick
);
  p_req_keeps_clock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(clk_req) & ~NOGATE_MASK & ~clk_en) == '0));

  p_awake_keeps_clock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((~$past(sleep_vec) & ~clk_en) == '0));

  p_plain_bits_follow_sleep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((NOGATE_MASK & $past(sleep_vec) & clk_en) == '0));

  p_zero_div_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(div_q) == '0) |-> !slow_tick);

  p_no_short_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_tick && div_q > DIV_W'(1)) |=> !slow_tick);
endmodule

bind periph_clk_gate_ctrl pcg_checker #(
  .NPER(NPER), .DIV_W(DIV_W), .NOGATE_MASK(NOGATE_MASK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sleep_vec(sleep_vec), .clk_req(clk_req),
  .clk_en(clk_en), .div_q(div_q), .slow_tick(slow_tick)
);

// File: tb/periph_clk_gate_ctrl_bench.sv
module periph_clk_gate_ctrl_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [3:0]   wr_addr = '0;
  logic [31:0]  wr_data = '0;
  logic [3:0]   rd_addr = '0;
  logic [31:0]  rd_data;
  logic [159:0] clk_req = '0;
  logic [159:0] clk_en;
  logic         slow_tick;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct {
    int          due;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sbq[$];

  localparam logic [159:0] PLAIN = 160'h7 << 122;

  periph_clk_gate_ctrl u_periph_clk_gate_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .clk_req(clk_req), .clk_en(clk_en), .slow_tick(slow_tick)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    item_t it;
    if (sbq.size() > 0 && sbq[0].due == cyc) begin
      it = sbq.pop_front();
      n_chk++;
      if (rd_data !== it.exp) begin
        n_bad++;
        $display("FAIL %s: rd_data=%h expected=%h", it.tag, rd_data, it.exp);
      end
    end
  end

  task automatic rd_chk(input logic [3:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    rd_addr = a;
    it.due = cyc + 1; it.exp = e; it.tag = tag;
    sbq.push_back(it);
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic en_chk(input logic [159:0] e, input string tag);
    n_chk++;
    if (clk_en !== e) begin
      n_bad++;
      $display("FAIL %s: clk_en=%h expected=%h", tag, clk_en, e);
    end
  endtask

  task automatic tick_chk(input int n, input int cycles, input string tag);
    int errs = 0;
    int first = 0;
    for (int m = 1; m <= cycles; m++) begin
      logic e;
      @(negedge clk);
      e = (n != 0) && (m % n == 0);
      if (slow_tick !== e) begin
        if (errs == 0) first = m;
        errs++;
      end
    end
    n_chk++;
    if (errs != 0) begin
      n_bad++;
      $display("FAIL %s: tick mismatches=%0d first at cycle %0d expected=0", tag, errs, first);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R9: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R6 reset state
    en_chk(~PLAIN, "R6 reset clk_en");
    rd_chk(4'd0, 32'h0, "R6 word0 reset");
    rd_chk(4'd3, 32'h1C000000, "R6 word3 reset");
    rd_chk(4'd4, 32'h0, "R6 word4 reset");
    rd_chk(4'd10, 32'h0, "R6 divider reset");
    tick_chk(0, 20, "R7 zero divider at reset");

    // R1 readback, R3 gating
    wr(4'd0, 32'hFFFF_FFFF);
    rd_chk(4'd0, 32'hFFFF_FFFF, "R1 word0 readback");
    en_chk(~PLAIN & ~160'hFFFF_FFFF, "R3 sleep set, no request");
    @(negedge clk);
    clk_req[5] = 1'b1;
    #1 en_chk(~PLAIN & ~160'hFFFF_FFFF, "R3 not combinational");
    @(negedge clk);
    en_chk(~PLAIN & ~160'hFFFF_FFDF, "R3 request keeps clock");
    clk_req[5] = 1'b0;
    @(negedge clk);
    en_chk(~PLAIN & ~160'hFFFF_FFFF, "R3 request dropped");

    // R4 sleep cleared
    wr(4'd0, 32'h0);
    @(negedge clk);
    en_chk(~PLAIN, "R4 sleep cleared");

    // R1 word4 top bit
    wr(4'd4, 32'h8000_0000);
    rd_chk(4'd4, 32'h8000_0000, "R1 word4 readback");
    en_chk(~PLAIN & ~(160'h1 << 159), "R1 peripheral 159 gated");
    wr(4'd4, 32'h0);

    // R5 plain bits ignore request
    clk_req[123] = 1'b1;
    repeat (2) @(negedge clk);
    en_chk(~PLAIN, "R5 request ignored with sleep set");
    wr(4'd3, 32'h0);
    clk_req[123] = 1'b0;
    @(negedge clk);
    en_chk({160{1'b1}}, "R5 sleep clear turns plain clocks on");
    wr(4'd3, 32'h1C000000);
    @(negedge clk);
    en_chk(~PLAIN, "R5 plain clocks off again");

    // R2 status words
    clk_req[63:32] = 32'hA5A5_0F0F;
    clk_req[159:128] = 32'h1234_5678;
    rd_chk(4'd6, 32'hA5A5_0F0F, "R2 status word1");
    rd_chk(4'd9, 32'h1234_5678, "R2 status word4");
    wr(4'd6, 32'hFFFF_FFFF);
    rd_chk(4'd6, 32'hA5A5_0F0F, "R2 write to status ignored");
    rd_chk(4'd1, 32'h0, "R2 sleep word1 untouched");
    en_chk(~PLAIN, "R2 clk_en untouched");
    clk_req = '0;

    // R9 unmapped
    rd_chk(4'd12, 32'h0, "R9 unmapped address");
    rd_chk(4'd15, 32'h0, "R9 top address");

    // R8 / R7 divider
    wr(4'd10, 32'd1);
    tick_chk(1, 8, "R8 divide by 1");
    wr(4'd10, 32'd3);
    tick_chk(3, 15, "R8 divide by 3");
    wr(4'd10, 32'd5);
    tick_chk(5, 20, "R8 divide by 5");
    rd_chk(4'd10, 32'd5, "R9 divider readback");
    wr(4'd10, 32'd0);
    tick_chk(0, 20, "R7 divider zero stops");
    wr(4'd10, 32'd4);
    repeat (2) @(negedge clk);
    wr(4'd10, 32'd4);
    tick_chk(4, 16, "R8 rewrite restarts count");

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule